// File: doc/BRIEF.md
# Printer Handshake Receiver

This block is the printer end of a byte-wide parallel link. A controller places a byte on the data input and issues a transfer strobe one clock cycle wide. The block accepts the strobe only while it reports ready, stores the byte, and pulls its ready line low for a fixed number of cycles that stands in for print time. When that time is over, it raises ready again and pulses a completion flag. The stored byte is visible on an output at all times.

An 8-bit tally counts the accepted bytes, so a test harness can confirm that an ascending byte stream arrives complete and in order. A strobe that arrives while the block is busy breaks the handshake. The block discards it and sets a sticky error flag that only reset clears.

Top module: `prn_sink`

## Requirements
- R1: A synchronous active-high reset puts the block in this state: ready_o=1, byte_o=0, done_o=0, accepted_o=0, proto_err_o=0.
- R2: On a rising clock edge where stb_i=1 and ready_o=1, the value of data_i is stored and shows on byte_o from the next cycle until the next accepted strobe.
- R3: The block goes busy in the cycle after an accepted strobe: ready_o is 0 there.
- R4: After an accepted strobe, ready_o stays 0 for exactly BUSY_CYCLES consecutive cycles (default 4) and then returns to 1.
- R5: done_o is 1 for exactly one cycle, namely the first cycle in which ready_o is 1 again after a busy period. It is 0 at all other times.
- R6: A strobe sampled while ready_o=0 (including the last busy cycle) is discarded: byte_o, accepted_o and the length of the busy period do not change.
- R7: proto_err_o becomes 1 in the cycle after a discarded strobe and stays 1 until reset.
- R8: accepted_o increases by one, modulo 256, in the cycle after each accepted strobe and changes at no other time.
- R9: While ready_o=1 and stb_i=0, the block stays idle: ready_o stays 1, and byte_o and accepted_o hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stb_i | input | 1 | One-cycle transfer strobe from the controller |
| data_i | input | DATA_W (8) | Byte to be printed |
| ready_o | output | 1 | 1 = idle and able to take a byte, 0 = printing |
| byte_o | output | DATA_W (8) | Last accepted byte |
| done_o | output | 1 | One-cycle pulse when printing of a byte is finished |
| accepted_o | output | CNT_W (8) | Number of accepted bytes, wrapping |
| proto_err_o | output | 1 | Sticky flag: a strobe arrived while busy |

## Verification
The first directed test is a single isolated byte, which separates an off-by-one in the busy length from a correct one. Next comes a strobe placed in the first idle cycle after a busy period, which shows whether the block is ready again on time. A strobe issued in the final busy cycle must be rejected, because the block is still busy there. A run of more than 256 strictly ascending bytes tests ordering and wrap of the tally. A seeded random phase follows, with strobes at random gaps and with data values that change while the block is busy. It exercises acceptance and rejection at every point of the busy window. A mid-run reset shows that the error flag and the tally clear.

// File: rtl/prn_pkg.sv
package prn_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_BUSY = 1'b1
    } prn_phase_e;

    localparam int unsigned DEF_DATA_W = 8;
    localparam int unsigned DEF_CNT_W  = 8;
    localparam int unsigned DEF_BUSY   = 4;

    // Width large enough to hold values 0..n.
    function automatic int unsigned span_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/prn_busy_timer.sv
module prn_busy_timer
    import prn_pkg::*;
#(
    parameter int unsigned BUSY_CYCLES = DEF_BUSY
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic finish
);
    localparam int unsigned TW = span_bits(BUSY_CYCLES);
    localparam logic [TW-1:0] LOAD = TW'(BUSY_CYCLES - 1);

    prn_phase_e    phase;
    logic [TW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            left   <= '0;
            finish <= 1'b0;
        end else begin
            finish <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_BUSY;
                        left  <= LOAD;
                    end
                end
                PH_BUSY: begin
                    if (left == '0) begin
                        phase  <= PH_IDLE;
                        finish <= 1'b1;
                    end else begin
                        left <= left - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy = (phase == PH_BUSY);
endmodule

// File: rtl/prn_capture.sv
module prn_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst)       dout <= '0;
        else if (take) dout <= din;
    end
endmodule

// File: rtl/prn_tally.sv
module prn_tally #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             stray,
    output logic [CNT_W-1:0] count,
    output logic             err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            err   <= 1'b0;
        end else begin
            if (take)  count <= count + 1'b1;
            if (stray) err   <= 1'b1;
        end
    end
endmodule

// File: rtl/prn_sink.sv
module prn_sink
    import prn_pkg::*;
#(
    parameter int unsigned DATA_W      = DEF_DATA_W,
    parameter int unsigned CNT_W       = DEF_CNT_W,
    parameter int unsigned BUSY_CYCLES = DEF_BUSY
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              ready_o,
    output logic [DATA_W-1:0] byte_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  accepted_o,
    output logic              proto_err_o
);
    logic busy;
    logic take;
    logic stray;

    assign take  = stb_i & ~busy;
    assign stray = stb_i &  busy;

    prn_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (take),
        .busy   (busy),
        .finish (done_o)
    );

    prn_capture #(.DATA_W(DATA_W)) u_cap (
        .clk  (clk),
        .rst  (rst),
        .take (take),
        .din  (data_i),
        .dout (byte_o)
    );

    prn_tally #(.CNT_W(CNT_W)) u_tally (
        .clk   (clk),
        .rst   (rst),
        .take  (take),
        .stray (stray),
        .count (accepted_o),
        .err   (proto_err_o)
    );

    assign ready_o = ~busy;
endmodule

// File: rtl/prn_sink_chk.sv
module prn_sink_chk #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned BUSY_CYCLES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              stb_i,
    input logic [DATA_W-1:0] data_i,
    input logic              ready_o,
    input logic [DATA_W-1:0] byte_o,
    input logic              done_o,
    input logic [CNT_W-1:0]  accepted_o,
    input logic              proto_err_o
);
    logic [31:0] low_run;

    always_ff @(posedge clk) begin
        if (rst)           low_run <= '0;
        else if (!ready_o) low_run <= low_run + 1;
        else               low_run <= '0;
    end

    AST_ACCEPT_STORES: assert property (@(posedge clk) disable iff (rst)
        (stb_i && ready_o) |=> (byte_o == $past(data_i))); // R2
    AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (rst)
        (stb_i && ready_o) |=> !ready_o); // R3
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
        (!ready_o && low_run == 32'(BUSY_CYCLES)) |-> 1'b0); // R4
    AST_BUSY_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> (low_run == 32'(BUSY_CYCLES))); // R4
    AST_DONE_ON_RETURN: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (ready_o && $rose(ready_o))); // R5
    AST_RETURN_FLAGS_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> done_o); // R5
    AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (stb_i && !ready_o) |=> ($stable(byte_o) && $stable(accepted_o))); // R6
    AST_STRAY_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (stb_i && !ready_o) |=> proto_err_o); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        proto_err_o |=> proto_err_o); // R7
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (stb_i && ready_o) |=> (accepted_o == $past(accepted_o) + 1'b1)); // R8
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(stb_i && ready_o) |=> $stable(accepted_o)); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (ready_o && !stb_i) |=> (ready_o && $stable(byte_o))); // R9
    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (ready_o && byte_o == '0 && !done_o && accepted_o == '0 && !proto_err_o)); // R1
endmodule

bind prn_sink prn_sink_chk #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
    .clk(clk), .rst(rst), .stb_i(stb_i), .data_i(data_i),
    .ready_o(ready_o), .byte_o(byte_o), .done_o(done_o),
    .accepted_o(accepted_o), .proto_err_o(proto_err_o)
);

// File: tb/tb_prn_sink.sv
`timescale 1ns/1ps
module tb_prn_sink;
    localparam int BUSY = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stb = 1'b0;
    logic [7:0] din = '0;
    logic       ready, done, perr;
    logic [7:0] bout, acc;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference state
    bit       m_ready = 1;
    int       m_left  = 0;
    bit [7:0] m_byte  = 0;
    bit       m_done  = 0;
    bit [7:0] m_cnt   = 0;
    bit       m_err   = 0;

    always #2.5 clk = ~clk;

    prn_sink #(.DATA_W(8), .CNT_W(8), .BUSY_CYCLES(BUSY)) dut (
        .clk(clk), .rst(rst), .stb_i(stb), .data_i(din),
        .ready_o(ready), .byte_o(bout), .done_o(done),
        .accepted_o(acc), .proto_err_o(perr)
    );

    function automatic bit [7:0] next_tally(input bit [7:0] c);
        return c + 8'd1;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_ready = 1; m_left = 0; m_byte = 0; m_done = 0; m_cnt = 0; m_err = 0;
    endtask

    task automatic model_step(input bit s, input bit [7:0] d);
        m_done = 0;
        if (m_ready) begin
            if (s) begin
                m_byte = d; m_cnt = next_tally(m_cnt); m_ready = 0; m_left = BUSY;
            end
        end else begin
            if (s) m_err = 1;
            m_left--;
            if (m_left == 0) begin m_ready = 1; m_done = 1; end
        end
    endtask

    // one clock cycle with full comparison
    task automatic cycle(input bit s, input bit [7:0] d);
        bit was_ready;
        @(negedge clk);
        stb = s; din = d;
        was_ready = m_ready;
        @(posedge clk);
        model_step(s, d);
        #1;
        if (s && !was_ready) begin
            check("R6 byte kept after busy strobe", bout, m_byte);
            check("R6 tally kept after busy strobe", acc, m_cnt);
            check("R7 error set", perr, 1);
        end else if (!s && was_ready) begin
            check("R9 idle ready", ready, 1);
            check("R9 idle byte", bout, m_byte);
        end
        check(s && was_ready ? "R3 ready after accept" : "R4 ready", ready, m_ready);
        check("R2 byte", bout, m_byte);
        check("R5 done", done, m_done);
        check("R8 tally", acc, m_cnt);
        check("R7 sticky error", perr, m_err);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; stb = 0;
        @(posedge clk); @(posedge clk);
        #1;
        model_reset();
        check("R1 ready", ready, 1);
        check("R1 byte", bout, 0);
        check("R1 done", done, 0);
        check("R1 tally", acc, 0);
        check("R1 error", perr, 0);
        @(negedge clk);
        rst = 0;
    endtask

    task automatic wait_ready();
        while (!m_ready) cycle(0, 8'hEE);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit [7:0] seq;
        bit prev;
        void'($urandom(32'd1234));
        do_reset();

        // single isolated byte
        cycle(1, 8'h41);
        wait_ready();
        cycle(0, 8'h00);

        // back-to-back: strobe in the first ready cycle
        cycle(1, 8'h5A);
        wait_ready();
        cycle(1, 8'hA5);
        // strobe in the last busy cycle -> rejected
        for (int i = 0; i < BUSY - 1; i++) cycle(0, 8'h00);
        cycle(1, 8'h77);
        cycle(0, 8'h00);
        check("R6 rejected value absent", bout, 8'hA5);

        do_reset();
        // ascending stream over wrap
        seq = 8'h00;
        for (int n = 0; n < 300; n++) begin
            wait_ready();
            cycle(1, seq);
            check("R2 ordered byte", bout, seq);
            seq = seq + 8'd1;
        end
        wait_ready();
        check("R8 tally wrapped", acc, 300 % 256);
        check("R7 no error on clean stream", perr, 0);

        // random phase
        prev = 0;
        for (int n = 0; n < 4000; n++) begin
            bit s;
            s = ($urandom % 4 == 0) && !prev;
            cycle(s, 8'($urandom));
            prev = s;
        end

        do_reset();
        for (int n = 0; n < 200; n++) cycle(($urandom % 3) == 0, 8'($urandom));

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule